// File: doc/BRIEF.md
# Parallel Port Extended Control Register

This block holds the extended control byte of a parallel port with a FIFO and DMA. A host writes and reads it over a byte-wide register bus at one fixed address in the port window. The byte holds a three-bit operating mode, an active-low enable for the fault interrupt, a DMA enable and a service bit. Two read-only flags show whether the FIFO is full or empty.

The block watches the external fault line and pulses an interrupt when that line falls. A pulse also comes when software enables the interrupt while the fault is already asserted, so an event that falls between a read and a write is not lost. While the service bit is clear, hardware sets it on the first qualifying condition and pulses a service interrupt. The condition is chosen by the DMA enable and the transfer direction: DMA terminal count, free FIFO space reaching the write threshold, or held FIFO bytes reaching the read threshold. The FIFO storage and the port handshake sit outside the block. It sees them only as a fill level and direction input, and it drives a FIFO reset and a data-drive enable back to them.

Top module: `pp_ecr`

## Requirements
- R1: After reset the register reads 0x15 with an empty FIFO: mode 000 in bits 7:5, error-interrupt disable (bit 4) 1, DMA enable (bit 3) 0, service bit (bit 2) 1, full (bit 1) 0, empty (bit 0) 1.
- R2: A write at the register address loads bits 7:5, 4, 3 and 2, and a read returns them in the same positions. Any other address reads 0.
- R3: Bit 1 reads 1 exactly when the fill level equals the FIFO depth. Bit 0 reads 1 exactly when the fill level is 0. Writes do not change either bit.
- R4: `fifo_rst` is 1 exactly while the mode is 000. `pdata_drive` is 1 in mode 000 whatever the direction input is. In every other mode it is the inverse of `port_dir`.
- R5: With bit 3 at 0 and `port_dir` at 0, a cleared service bit is set on the clock edge after free space (depth minus level) is at or above `wr_thresh`. `svc_irq` pulses high for that one cycle.
- R6: With bit 3 at 0 and `port_dir` at 1, a cleared service bit is set and `svc_irq` pulses when the fill level is at or above `rd_thresh`.
- R7: With bit 3 at 1, only `dma_tc` sets the service bit and pulses `svc_irq`. The thresholds have no effect.
- R8: `dma_req_en` is 1 only while bit 3 is 1 and the service bit is 0.
- R9: A software write to the service bit takes priority over a hardware set in the same cycle. Writing 1 never pulses `svc_irq`.
- R10: With bit 4 at 0, a falling edge on `fault_n` gives a one-cycle `err_irq` pulse three clock edges after it reaches the input (two synchroniser flops, then the edge detector). With bit 4 at 1, no pulse is given.
- R11: A write that changes bit 4 from 1 to 0 while the synchronised fault is low pulses `err_irq` on that write's clock edge. Doing so while the fault is high gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| fault_n | input | 1 | Asynchronous active-low fault line |
| fifo_level | input | CNT_W | Bytes currently held in the FIFO |
| port_dir | input | 1 | Transfer direction, 1 = toward the host |
| rd_thresh | input | CNT_W | Held-byte threshold for the service event |
| wr_thresh | input | CNT_W | Free-space threshold for the service event |
| dma_tc | input | 1 | DMA terminal count reached |
| err_irq | output | 1 | One-cycle fault interrupt pulse |
| svc_irq | output | 1 | One-cycle service interrupt pulse |
| dma_req_en | output | 1 | DMA request permission |
| fifo_rst | output | 1 | Holds the FIFO in reset |
| pdata_drive | output | 1 | Data lines driven (1) or released (0) |

## Verification
The hardest case to reach from the ports is the lost-event window. The fault has to be already asserted and synchronised, with its interrupt masked, and only then does software clear the mask. The bench first lets the falling edge pass while masked and checks over several cycles that no pulse comes. Only then does it write the enable, so the pulse can come only from the write path. A close second is the race between a software write to the service bit and a hardware set. The bench makes the threshold condition true on the same edge that carries the write of 1. It also sweeps every level and threshold pair in both directions and checks the set against a comparison computed in the bench.

// File: rtl/pp_ecr_pkg.sv
// Package: shared types and constants for the extended control register.
// Assumes the register is one byte wide; the field order is fixed by the
// software-visible layout.
package pp_ecr_pkg;

    localparam logic [2:0] MODE_COMPAT = 3'b000;

    // Software view of the control byte, most significant field first.
    typedef struct packed {
        logic [2:0] mode;
        logic       err_dis;
        logic       dma_en;
        logic       svc;
        logic       full;
        logic       empty;
    } ecr_view_t;

endpackage

// File: rtl/pp_ecr_fault.sv
// pp_ecr_fault: brings the asynchronous fault line into the clock domain with
// two flops, finds its falling edge and forms the error interrupt pulse.
// Assumes err_clr is a one-cycle strobe for a write that drops the mask.
module pp_ecr_fault (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_n,
    input  logic err_dis,
    input  logic err_clr,
    output logic err_irq
);
    logic sync1_q;
    logic sync2_q;
    logic prev_q;
    logic fall;

    // Two-stage synchroniser plus one history flop, idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b1;
            sync2_q <= 1'b1;
            prev_q  <= 1'b1;
        end else begin
            sync1_q <= fault_n;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    assign fall = prev_q & ~sync2_q;

    // Pulse on an unmasked edge, or when the mask drops while the fault is low.
    always_ff @(posedge clk) begin
        if (!rst_n) err_irq <= 1'b0;
        else        err_irq <= (fall & ~err_dis) | (err_clr & ~sync2_q);
    end
endmodule

// File: rtl/pp_ecr_svc.sv
// pp_ecr_svc: picks the service condition from the DMA enable and the
// direction. Assumes fifo_level never exceeds DEPTH; larger values are
// treated as full.
module pp_ecr_svc #(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             dma_en,
    input  logic             dir,
    input  logic             dma_tc,
    input  logic [CNT_W-1:0] level,
    input  logic [CNT_W-1:0] rd_thresh,
    input  logic [CNT_W-1:0] wr_thresh,
    output logic             svc_evt,
    output logic             full,
    output logic             empty
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    logic [CNT_W-1:0] free_cnt;

    // Free space, clamped at zero.
    always_comb begin
        free_cnt = (level >= DEPTH_C) ? '0 : DEPTH_C - level;
    end

    // Service condition selection.
    always_comb begin
        if (dma_en)   svc_evt = dma_tc;
        else if (dir) svc_evt = (level >= rd_thresh);
        else          svc_evt = (free_cnt >= wr_thresh);
    end

    assign full  = (level >= DEPTH_C);
    assign empty = (level == '0);
endmodule

// File: rtl/pp_ecr_regs.sv
// pp_ecr_regs: holds the writable fields and the service bit, and raises the
// service interrupt. A host write wins over a hardware set in the same cycle.
module pp_ecr_regs (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_hit,
    input  logic [7:0] wdata,
    input  logic       svc_evt,
    output logic [2:0] mode,
    output logic       err_dis,
    output logic       dma_en,
    output logic       svc,
    output logic       svc_irq,
    output logic       err_clr
);
    // Strobe for a write that drops the error mask from 1 to 0.
    assign err_clr = wr_hit & err_dis & ~wdata[4];

    // Register fields and service set/pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode    <= pp_ecr_pkg::MODE_COMPAT;
            err_dis <= 1'b1;
            dma_en  <= 1'b0;
            svc     <= 1'b1;
            svc_irq <= 1'b0;
        end else if (wr_hit) begin
            mode    <= wdata[7:5];
            err_dis <= wdata[4];
            dma_en  <= wdata[3];
            svc     <= wdata[2];
            svc_irq <= 1'b0;
        end else begin
            svc_irq <= ~svc & svc_evt;
            if (~svc & svc_evt) svc <= 1'b1;
        end
    end
endmodule

// File: rtl/pp_ecr.sv
// pp_ecr: top of the extended control register. Decodes the one register
// address, assembles the read view and drives the port-side controls.
// Assumes one host write per strobe cycle; reads have no side effects.
module pp_ecr #(
    parameter int              ADDR_W     = 11,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 11'h402,
    parameter int              DEPTH      = 16,
    parameter int              CNT_W      = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              fault_n,
    input  logic [CNT_W-1:0]  fifo_level,
    input  logic              port_dir,
    input  logic [CNT_W-1:0]  rd_thresh,
    input  logic [CNT_W-1:0]  wr_thresh,
    input  logic              dma_tc,
    output logic              err_irq,
    output logic              svc_irq,
    output logic              dma_req_en,
    output logic              fifo_rst,
    output logic              pdata_drive
);
    import pp_ecr_pkg::*;

    logic       addr_hit;
    logic       wr_hit;
    logic [2:0] mode_q;
    logic       err_dis_q;
    logic       dma_en_q;
    logic       svc_q;
    logic       err_clr;
    logic       svc_evt;
    logic       full;
    logic       empty;
    ecr_view_t  view;

    assign addr_hit = (bus_addr == REG_OFFSET);
    assign wr_hit   = bus_wr & addr_hit;

    pp_ecr_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (wr_hit),
        .wdata   (bus_wdata),
        .svc_evt (svc_evt),
        .mode    (mode_q),
        .err_dis (err_dis_q),
        .dma_en  (dma_en_q),
        .svc     (svc_q),
        .svc_irq (svc_irq),
        .err_clr (err_clr)
    );

    pp_ecr_svc #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_svc (
        .dma_en    (dma_en_q),
        .dir       (port_dir),
        .dma_tc    (dma_tc),
        .level     (fifo_level),
        .rd_thresh (rd_thresh),
        .wr_thresh (wr_thresh),
        .svc_evt   (svc_evt),
        .full      (full),
        .empty     (empty)
    );

    pp_ecr_fault u_fault (
        .clk     (clk),
        .rst_n   (rst_n),
        .fault_n (fault_n),
        .err_dis (err_dis_q),
        .err_clr (err_clr),
        .err_irq (err_irq)
    );

    // Assemble the software view.
    always_comb begin
        view.mode    = mode_q;
        view.err_dis = err_dis_q;
        view.dma_en  = dma_en_q;
        view.svc     = svc_q;
        view.full    = full;
        view.empty   = empty;
    end

    assign bus_rdata   = addr_hit ? view : 8'h00;
    assign dma_req_en  = dma_en_q & ~svc_q;
    assign fifo_rst    = (mode_q == MODE_COMPAT);
    assign pdata_drive = (mode_q == MODE_COMPAT) ? 1'b1 : ~port_dir;
endmodule

// File: rtl/pp_ecr_chk.sv
// pp_ecr_chk: temporal checks on the extended control register, bound into
// every instance of the top.
module pp_ecr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_hit,
    input logic [7:0] bus_wdata,
    input logic       err_irq,
    input logic       svc_irq,
    input logic       svc_q,
    input logic       err_dis_q,
    input logic       dma_en_q,
    input logic       err_clr,
    input logic       dma_tc,
    input logic       fifo_rst
);
    AST_SVC_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        svc_irq |=> !svc_irq);                                                   // R5
    AST_SVC_FROM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        svc_irq |-> !$past(svc_q));                                              // R9
    AST_TC_ONLY_IN_DMA: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(svc_q) && !$past(wr_hit) && $past(dma_en_q)) |-> $past(dma_tc));  // R7
    AST_ERR_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> (!$past(err_dis_q) || $past(err_clr)));                      // R10
    AST_ERR_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |=> !err_irq);                                                   // R11
    AST_COMPAT_FIFO_RST: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_hit) && $past(bus_wdata[7:5]) == 3'b000) |-> fifo_rst);        // R4
endmodule

bind pp_ecr pp_ecr_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_hit    (wr_hit),
    .bus_wdata (bus_wdata),
    .err_irq   (err_irq),
    .svc_irq   (svc_irq),
    .svc_q     (svc_q),
    .err_dis_q (err_dis_q),
    .dma_en_q  (dma_en_q),
    .err_clr   (err_clr),
    .dma_tc    (dma_tc),
    .fifo_rst  (fifo_rst)
);

// File: tb/pp_ecr_tb.sv
module pp_ecr_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 11;
    localparam logic [ADDR_W-1:0] OFF = 11'h402;
    localparam int DEPTH = 8;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = OFF;
    logic bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic fault_n = 1'b1;
    logic [CNT_W-1:0] fifo_level = '0;
    logic port_dir = 1'b0;
    logic [CNT_W-1:0] rd_thresh = '0;
    logic [CNT_W-1:0] wr_thresh = '0;
    logic dma_tc = 1'b0;
    logic err_irq, svc_irq, dma_req_en, fifo_rst, pdata_drive;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pp_ecr #(.ADDR_W(ADDR_W), .REG_OFFSET(OFF), .DEPTH(DEPTH), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fault_n(fault_n),
        .fifo_level(fifo_level), .port_dir(port_dir), .rd_thresh(rd_thresh),
        .wr_thresh(wr_thresh), .dma_tc(dma_tc), .err_irq(err_irq),
        .svc_irq(svc_irq), .dma_req_en(dma_req_en), .fifo_rst(fifo_rst),
        .pdata_drive(pdata_drive)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One-cycle write; returns at the falling edge after the write edge.
    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        bus_addr = OFF; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset value
        chk("R1 reset view", bus_rdata, 8'h15);
        chk("R1 no pulses", {err_irq, svc_irq, dma_req_en}, 0);
        // R2 other address reads zero
        bus_addr = OFF + 1;
        #1 chk("R2 other address", bus_rdata, 0);
        bus_addr = OFF;

        // R2 R4 mode sweep with service bit held at 1
        for (int m = 0; m < 8; m++) begin
            for (int d = 0; d < 2; d++) begin
                port_dir = d[0];
                wr({m[2:0], 1'b1, 1'b0, 1'b1, 2'b00});
                chk("R2 mode readback", bus_rdata[7:2], {m[2:0], 3'b101});
                chk("R4 fifo reset", fifo_rst, (m == 0) ? 1 : 0);
                chk("R4 data drive", pdata_drive, (m == 0) ? 1 : (d == 0 ? 1 : 0));
            end
        end
        port_dir = 1'b0;

        // R3 full/empty sweep; a write of ones to bits 1:0 has no effect
        wr(8'b010_1_0_1_11);
        for (int l = 0; l <= DEPTH; l++) begin
            fifo_level = l[CNT_W-1:0];
            #1 chk("R3 flags", bus_rdata[1:0], {(l == DEPTH) ? 1'b1 : 1'b0, (l == 0) ? 1'b1 : 1'b0});
        end

        // R5 R6 threshold sweep, DMA off
        for (int d = 0; d < 2; d++) begin
            for (int l = 0; l <= DEPTH; l++) begin
                for (int t = 0; t <= DEPTH; t++) begin
                    bit exp_set;
                    wr(8'b010_1_0_1_00);
                    port_dir = d[0];
                    fifo_level = l[CNT_W-1:0];
                    rd_thresh = t[CNT_W-1:0];
                    wr_thresh = t[CNT_W-1:0];
                    exp_set = (d == 1) ? (l >= t) : ((DEPTH - l) >= t);
                    wr(8'b010_1_0_0_00);
                    @(negedge clk);
                    if (d == 1) begin
                        chk("R6 svc pulse", svc_irq, exp_set);
                        chk("R6 svc bit", bus_rdata[2], exp_set);
                    end else begin
                        chk("R5 svc pulse", svc_irq, exp_set);
                        chk("R5 svc bit", bus_rdata[2], exp_set);
                    end
                    @(negedge clk);
                    chk("R5 pulse one cycle", svc_irq, 0);
                end
            end
        end

        // R9 write of 1 on the same edge the condition becomes true
        port_dir = 1'b0; fifo_level = 4'd1; wr_thresh = 4'd8;
        wr(8'b010_1_0_0_00);
        chk("R9 svc cleared", bus_rdata[2], 0);
        bus_wr = 1'b1; bus_wdata = 8'b010_1_0_1_00; fifo_level = 4'd0;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R9 no pulse on write", svc_irq, 0);
        @(negedge clk);
        chk("R9 no pulse after", svc_irq, 0);
        chk("R9 svc set by write", bus_rdata[2], 1);

        // R7 R8 DMA mode: thresholds true but ignored, only terminal count sets
        wr(8'b010_1_1_0_00);
        chk("R8 dma enabled", dma_req_en, 1);
        @(negedge clk);
        chk("R7 thresholds ignored", svc_irq, 0);
        chk("R7 svc stays clear", bus_rdata[2], 0);
        dma_tc = 1'b1;
        @(negedge clk);
        dma_tc = 1'b0;
        chk("R7 tc pulse", svc_irq, 1);
        chk("R8 dma gated", dma_req_en, 0);
        wr(8'b010_1_0_0_00);
        chk("R8 dma disabled", dma_req_en, 0);
        wr(8'b010_1_0_1_00);

        // R10 unmasked falling edge: pulse on the third edge
        wr(8'b010_0_0_1_00);
        fault_n = 1'b0;
        @(negedge clk); chk("R10 edge1", err_irq, 0);
        @(negedge clk); chk("R10 edge2", err_irq, 0);
        @(negedge clk); chk("R10 edge3 pulse", err_irq, 1);
        @(negedge clk); chk("R10 one cycle", err_irq, 0);
        fault_n = 1'b1;
        repeat (4) @(negedge clk);

        // R10 masked edge gives nothing; R11 unmask while low pulses
        wr(8'b010_1_0_1_00);
        fault_n = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); chk("R10 masked", err_irq, 0);
        end
        wr(8'b010_0_0_1_00);
        chk("R11 unmask while asserted", err_irq, 1);
        @(negedge clk);
        chk("R11 one cycle", err_irq, 0);

        // R11 unmask while fault high: no pulse
        fault_n = 1'b1;
        repeat (4) @(negedge clk);
        wr(8'b010_1_0_1_00);
        wr(8'b010_0_0_1_00);
        chk("R11 unmask while idle", err_irq, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule